// File: doc/BRIEF.md
# Serial EEPROM Burst Reader

This block is an SPI master that pulls a contiguous run of bytes out of a serial EEPROM. A single pulse on `start` captures a 24-bit start address and a byte count. The block lowers chip select and shifts out a read command followed by the address. It then keeps the clock running for as many bytes as were requested and hands each received byte to the surrounding logic with a one-cycle strobe.

A typical use is a boot-time loader: after reset, a sequencer starts one burst and streams the payload into a FIFO or a configuration register file. The whole burst is a single bus transaction, so the EEPROM's internal address counter advances by itself and any region length fits in one request.

Top module: `eeprom_burst_reader`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, chip select is high, the serial clock is low, and `busy`, `done` and `rdValid` are low.
- R2: A start that arrives with a non-zero count while idle makes chip select low and `busy` high on the next clock edge. The first eight bits on MOSI are the read command 0x03, most significant bit first.
- R3: The next 24 MOSI bits carry the captured start address, most significant bit first.
- R4: After those 32 header bits, MOSI stays 0 for every data bit.
- R5: The serial clock idles low. Each of its high and low phases lasts CLK_DIV/2 system cycles (CLK_DIV even, at least 2). MOSI changes only when the serial clock falls, and MISO is sampled when it rises.
- R6: Each data byte is assembled most significant bit first. `rdData` is updated and `rdValid` pulses for exactly one cycle on the clock edge that raises the serial clock for that byte's eighth bit. Consecutive bytes come from consecutive EEPROM addresses.
- R7: Chip select stays low through the whole burst and rises with the final falling serial-clock edge. It then stays high for CLK_DIV cycles, after which `done` pulses for one cycle and `busy` falls on the same edge.
- R8: While `busy` is high, `start` and any change of address or count are ignored.
- R9: A start with a count of zero raises `done` on the next edge. Chip select stays high and `busy` stays low.
- R10: A start that is present in the cycle where `done` is high is accepted, and it begins a new burst on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a burst; sampled only while idle |
| startAddr | input | 24 | First EEPROM byte address |
| byteCount | input | CNT_W (16) | Number of bytes to read |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| rdData | output | 8 | Last byte received |
| rdValid | output | 1 | One-cycle strobe for `rdData` |
| spiSck | output | 1 | Serial clock, mode 0 |
| spiMosi | output | 1 | Serial data to the EEPROM |
| spiMiso | input | 1 | Serial data from the EEPROM |
| spiCsN | output | 1 | Active-low chip select |

## Verification
The end of one request and the acceptance of the next can fall in the same cycle. `done` is high while `start` is already being sampled, so a back-to-back request collides with the completion pulse. The bench holds `start` high across a whole burst and changes the address and count while the burst runs. This must leave that burst untouched and must launch a second burst with the new values on the edge right after `done`. A cycle-by-cycle model in the bench predicts every pin and strobe for both bursts, including the zero-count case where `done` and acceptance coincide on the very edge that samples `start`.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  localparam int ADDR_W   = 24;
  localparam int HDR_BITS = 8 + ADDR_W;
  localparam logic [7:0] READ_OP = 8'h03;

  typedef struct packed {
    logic load;       // capture command and address into the out-shifter
    logic shiftOut;   // advance MOSI on a falling serial clock
    logic sampleIn;   // take MISO on a rising serial clock
    logic byteLast;   // current bit is the eighth bit of a data byte
    logic dataPhase;  // header already sent
  } ebrStrobe_t;
endpackage

// File: rtl/ebr_ctrl.sv
module ebr_ctrl
  import ebr_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output ebrStrobe_t       strb,
  output logic             sck,
  output logic             csN,
  output logic             busy,
  output logic             done
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int PH_W  = $clog2(HALF) + 1;
  localparam int GAP_W = $clog2(CLK_DIV) + 1;
  localparam int BIT_W = CNT_W + 4;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} ctrlState_t;

  ctrlState_t       state;
  logic [PH_W-1:0]  phaseCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] lastBit;

  logic phaseEnd, riseNow, fallNow, lastBitNow, headerDone;

  always_comb begin
    phaseEnd   = (phaseCnt == PH_W'(HALF - 1));
    riseNow    = (state == ST_XFER) && phaseEnd && !sck;
    fallNow    = (state == ST_XFER) && phaseEnd && sck;
    lastBitNow = (bitCnt == lastBit);
    headerDone = (bitCnt >= BIT_W'(HDR_BITS));
    strb.load      = (state == ST_IDLE) && start && (count != '0);
    strb.shiftOut  = fallNow && !lastBitNow;
    strb.sampleIn  = riseNow;
    strb.byteLast  = headerDone && (bitCnt[2:0] == 3'd7);
    strb.dataPhase = (state == ST_XFER) && headerDone;
    busy = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      gapCnt   <= '0;
      bitCnt   <= '0;
      lastBit  <= '0;
      sck      <= 1'b0;
      csN      <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (count == '0) begin
              done <= 1'b1;
            end else begin
              state    <= ST_XFER;
              csN      <= 1'b0;
              sck      <= 1'b0;
              phaseCnt <= '0;
              bitCnt   <= '0;
              lastBit  <= BIT_W'(HDR_BITS - 1) + {1'b0, count, 3'b000};
            end
          end
        end
        ST_XFER: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            if (!sck) begin
              sck <= 1'b1;
            end else begin
              sck <= 1'b0;
              if (lastBitNow) begin
                state  <= ST_GAP;
                csN    <= 1'b1;
                gapCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: begin
          if (gapCnt == GAP_W'(CLK_DIV - 1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
      endcase
    end
  end

  a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);
  a_r7_cs_covers_sck: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !csN);
  a_r7_busy_drop_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && count != '0) |=> (!csN && busy));
  a_r9_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && count == '0) |=> (done && csN && !busy));
  a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/ebr_datapath.sv
module ebr_datapath
  import ebr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ebrStrobe_t        strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              miso,
  output logic              mosi,
  output logic [7:0]        dataOut,
  output logic              dataValid
);
  logic [HDR_BITS-1:0] shOut;
  logic [7:0]          shIn;

  assign mosi = shOut[HDR_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shOut     <= '0;
      shIn      <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      if (strb.load)
        shOut <= {READ_OP, startAddr};
      else if (strb.shiftOut)
        shOut <= {shOut[HDR_BITS-2:0], 1'b0};
      if (strb.sampleIn) begin
        shIn <= {shIn[6:0], miso};
        if (strb.byteLast) begin
          dataOut   <= {shIn[6:0], miso};
          dataValid <= 1'b1;
        end
      end
    end
  end

  a_r4_mosi_zero_in_data: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataPhase |-> !mosi);
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);
  a_r5_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.shiftOut && !strb.load) |=> $stable(mosi));
endmodule

// File: rtl/eeprom_burst_reader.sv
module eeprom_burst_reader
  import ebr_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              spiSck,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              spiCsN
);
  ebrStrobe_t strb;

  ebr_ctrl #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .count(byteCount),
    .strb(strb), .sck(spiSck), .csN(spiCsN), .busy(busy), .done(done)
  );

  ebr_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .miso(spiMiso), .mosi(spiMosi), .dataOut(rdData), .dataValid(rdValid)
  );
endmodule

// File: tb/sim_eeprom_burst_reader.sv
module sim_eeprom_burst_reader;
  localparam int CLK_DIV = 4;
  localparam int CNT_W   = 16;
  localparam int H       = CLK_DIV / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [23:0] startAddr = '0;
  logic [CNT_W-1:0] byteCount = '0;
  logic busy, done, rdValid, spiSck, spiMosi, spiMiso, spiCsN;
  logic [7:0] rdData;

  always #4 clk = ~clk;

  eeprom_burst_reader #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .byteCount(byteCount), .busy(busy), .done(done), .rdData(rdData),
    .rdValid(rdValid), .spiSck(spiSck), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  integer total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16];
  endfunction

  // EEPROM model: bit index counts falling serial-clock edges since chip select fell
  integer sBit = 0;
  logic [23:0] mAddr = '0;
  always @(negedge spiCsN) sBit = 0;
  always @(negedge spiSck) sBit = sBit + 1;

  function automatic logic slaveBit(input integer b, input logic [23:0] base);
    logic [7:0] v;
    if (b < 32) return 1'b1;
    v = memByte(base + 24'((b - 32) / 8));
    return v[7 - ((b - 32) % 8)];
  endfunction
  assign spiMiso = slaveBit(sBit, mAddr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, advanced at each rising edge
  bit mActive = 0, doneExp = 0, prevDone = 0, zeroDone = 0, chainedXfer = 0;
  integer aCyc = 0, nBits = 0, endD = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; doneExp = 0; cyc = 0; zeroDone = 0;
    end else begin
      cyc = cyc + 1;
      prevDone = doneExp;
      doneExp = 0;
      zeroDone = 0;
      if (mActive) begin
        if (cyc - aCyc == endD) begin
          mActive = 0;
          doneExp = 1;
        end
      end else if (start) begin
        if (byteCount == 0) begin
          doneExp = 1;
          zeroDone = 1;
        end else begin
          mActive = 1;
          chainedXfer = prevDone;
          aCyc = cyc;
          nBits = 32 + 8 * int'(byteCount);
          endD = 2 * nBits * H + CLK_DIV;
          mAddr = startAddr;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic expCs, expSck, expMosi, expValid;
      logic [7:0] expData;
      logic [31:0] hdr;
      string mosiTag;
      integer d, j, i;
      expCs = 1; expSck = 0; expMosi = 0; expValid = 0; expData = '0;
      mosiTag = "R4";
      hdr = {8'h03, mAddr};
      if (mActive) begin
        d = cyc - aCyc;
        j = d / H;
        if (j < 2 * nBits) begin
          expCs = 0;
          expSck = j[0];
          i = j / 2;
          if (i < 32) begin
            expMosi = hdr[31 - i];
            mosiTag = (i < 8) ? "R2" : "R3";
          end
          if ((d % (2 * H)) == H && i >= 32 && ((i - 32) % 8) == 7) begin
            expValid = 1;
            expData = memByte(mAddr + 24'((i - 32) / 8));
          end
        end
      end
      chk(spiCsN == expCs, "R7 chip select", 32'(spiCsN), 32'(expCs));
      chk(spiSck == expSck, "R5 serial clock", 32'(spiSck), 32'(expSck));
      chk(spiMosi == expMosi, {mosiTag, " mosi"}, 32'(spiMosi), 32'(expMosi));
      chk(busy == mActive, chainedXfer ? "R10 busy" : "R8 busy", 32'(busy), 32'(mActive));
      chk(done == doneExp, zeroDone ? "R9 done" : "R7 done", 32'(done), 32'(doneExp));
      chk(rdValid == expValid, "R6 valid", 32'(rdValid), 32'(expValid));
      if (expValid)
        chk(rdData == expData, "R6 data", 32'(rdData), 32'(expData));
    end
  end

  task automatic waitIdle();
    @(negedge clk);
    while (busy || mActive) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic request(input logic [23:0] a, input logic [CNT_W-1:0] n);
    @(negedge clk);
    startAddr = a;
    byteCount = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    startAddr = 24'h5A5A5A;
    byteCount = 7;
    waitIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(spiCsN == 1'b1, "R1 cs", 32'(spiCsN), 1);
    chk(spiSck == 1'b0, "R1 sck", 32'(spiSck), 0);
    chk(!busy && !done && !rdValid, "R1 status", {busy, done, rdValid}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    request(24'h123456, 3);
    request(24'hFFFFFE, 2);
    request(24'h000000, 0);
    request(24'h00A5C3, 1);
    // start held through a burst; new inputs while busy are ignored (R8), chained start (R10)
    @(negedge clk);
    startAddr = 24'h000010;
    byteCount = 2;
    start = 1'b1;
    @(negedge clk);
    startAddr = 24'h777777;
    byteCount = 1;
    while (!done) @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 chained accept", 32'(busy), 1);
    waitIdle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule